// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire PHY management bus. It runs Clause 22 management frames over a clock line (MDC) and a bidirectional data line (MDIO). Software fills a 16-bit data register and then writes a 32-bit control word. That word holds a start flag, a direction flag, a 3-bit code for the system-clock range, a PHY register number and a PHY address.

The block derives MDC from the system clock, using a divide ratio picked by the range code. It then shifts out a 64-bit frame. On reads it lets go of MDIO from the turnaround onward and captures the PHY's 16 data bits. The start flag clears itself when the last bit has left. That self-clearing flag is the only handshake software has: poll it, then read the data register.

Register access goes through a single-cycle port. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control word (byte offset 0x10) and the data register (byte offset 0x14) both read 0, MDC is low and `mdio_oe` is low.
- R2: While idle, control bits [15:11] store the PHY address, bits [10:6] the register number, bits [4:2] the range code and bit 1 the direction (1 = write, 0 = read). Bits 5 and 31:16 read 0, data register bits 31:16 read 0, and unmapped offsets read 0.
- R3: Writing the control word with bit 0 set while idle starts a frame. Bit 0 then reads 1 until exactly 64 MDC rising edges have occurred, and reads 0 afterwards. Writing the control word with bit 0 clear starts nothing.
- R4: The MDC period in system clocks is 42, 62, 16, 26, 102 or 124 for range codes 0 to 5, and 124 for codes 6 and 7. MDC is high for half the period.
- R5: A write frame carries, MSB first: 32 ones, start 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10, then the 16 data-register bits. `mdio_oe` is high for all 64 bits.
- R6: A read frame uses opcode 10. `mdio_oe` is high for the first 46 bits and low from the turnaround onward. `mdio_i` is sampled on each MDC rising edge, and the last 16 samples, MSB first, are in the data register once bit 0 reads 0.
- R7: While a frame is running, writes to the control word or the data register are ignored.
- R8: While idle, MDC and `mdio_oe` stay low. `mdio_o` and `mdio_oe` change only while MDC is low, never during its high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The main function is run across all eight range codes, and read and write frames alternate between them. Measuring the MDC period and high time at each code separates the six ratios from one another and shows that codes 6 and 7 fall back to the code-5 ratio. Each write vector carries a different PHY address, register number and data word, which exposes field-ordering and bit-reversal errors in the serialized frame. Each read vector returns a different PHY response, which shows the capture shift order and that the turnaround release happens at bit 46. Every frame is also hit with ignored control and data writes while it runs, so a frame that can be corrupted in flight shows up in the ratio, the bit count or the readback.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h10,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h14,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_BITS = PRE_LEN + 32;
  localparam int TA_BIT     = PRE_LEN + 14;
  localparam int BN_W       = $clog2(FRAME_BITS + 1);

  function automatic logic [6:0] ratio_of(input logic [2:0] c);
    case (c)
      3'd0:    ratio_of = 7'd42;
      3'd1:    ratio_of = 7'd62;
      3'd2:    ratio_of = 7'd16;
      3'd3:    ratio_of = 7'd26;
      3'd4:    ratio_of = 7'd102;
      default: ratio_of = 7'd124;
    endcase
  endfunction

  logic                  busy, dir;
  logic [2:0]            code;
  logic [4:0]            reg_num, phy;
  logic [15:0]           data, rx;
  logic [FRAME_BITS-1:0] shift;
  logic [6:0]            cnt, ratio;
  logic [BN_W-1:0]       bitn;

  wire wr_ctrl = reg_wr && reg_addr == CTRL_OFS;
  wire wr_data = reg_wr && reg_addr == DATA_OFS;
  wire last    = bitn == BN_W'(FRAME_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; dir <= 1'b0; code <= '0; reg_num <= '0; phy <= '0;
      data <= '0; rx <= '0; shift <= '0; cnt <= '0; ratio <= 7'd124;
      bitn <= '0; mdc <= 1'b0;
    end else if (!busy) begin
      if (wr_ctrl) begin
        dir     <= reg_wdata[1];
        code    <= reg_wdata[4:2];
        reg_num <= reg_wdata[10:6];
        phy     <= reg_wdata[15:11];
        if (reg_wdata[0]) begin
          busy  <= 1'b1;
          ratio <= ratio_of(reg_wdata[4:2]);
          cnt   <= '0;
          bitn  <= '0;
          shift <= {{PRE_LEN{1'b1}}, 2'b01, reg_wdata[1] ? 2'b01 : 2'b10,
                    reg_wdata[15:11], reg_wdata[10:6],
                    reg_wdata[1] ? 2'b10 : 2'b00, data};
        end
      end
      if (wr_data) data <= reg_wdata[15:0];
    end else if (cnt == ratio - 7'd1) begin
      cnt   <= '0;
      mdc   <= 1'b0;
      shift <= {shift[FRAME_BITS-2:0], 1'b0};
      bitn  <= bitn + 1'b1;
      if (last) begin
        busy <= 1'b0;
        if (!dir) data <= rx;
      end
    end else begin
      cnt <= cnt + 7'd1;
      if (cnt == (ratio >> 1) - 7'd1) begin
        mdc <= 1'b1;
        rx  <= {rx[14:0], mdio_i};
      end
    end
  end

  assign mdio_o  = busy & shift[FRAME_BITS-1];
  assign mdio_oe = busy & (dir | (bitn < BN_W'(TA_BIT)));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_OFS)      reg_rdata[15:0] = {phy, reg_num, 1'b0, code, dir, busy};
    else if (reg_addr == DATA_OFS) reg_rdata[15:0] = data;
  end
endmodule

module mdio_master_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              start_bit,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic [6:0]        cnt,
  input logic [6:0]        ratio,
  input logic [15:0]       data,
  input logic [15:0]       cfg
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && reg_wr && reg_addr == CTRL_OFS && start_bit |=> busy); // R3
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < ratio); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(data)); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cfg)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdio_oe); // R8
  AST_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe)); // R8
endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .start_bit(reg_wdata[0]), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .cnt(cnt), .ratio(ratio), .data(data), .cfg({phy, reg_num, 2'b00, code, dir})
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_NS = 10;
  localparam logic [7:0] CTRL = 8'h10, DATA = 8'h14;

  // {code[29:27], dir[26], phy[25:21], reg[20:16], data[15:0]}
  localparam logic [29:0] VECS [8] = '{
    {3'd2, 1'b1, 5'h01, 5'h00, 16'hA5C3},
    {3'd3, 1'b0, 5'h1F, 5'h1E, 16'h3C5A},
    {3'd0, 1'b1, 5'h12, 5'h09, 16'h8001},
    {3'd1, 1'b0, 5'h0A, 5'h15, 16'hF00D},
    {3'd4, 1'b1, 5'h05, 5'h1A, 16'h1234},
    {3'd5, 1'b0, 5'h10, 5'h01, 16'h8421},
    {3'd6, 1'b1, 5'h1B, 5'h04, 16'hFFFE},
    {3'd7, 1'b0, 5'h03, 5'h1C, 16'h6DB7}
  };

  logic clk = 0, rst_n = 0, reg_wr = 0, mdio_i;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;

  mdio_master u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int idx = 0;
  logic [63:0] pat = '0, cap_o, cap_oe;
  time last_rise = 0, per = 0, hi = 0;

  assign mdio_i = (idx < 64) ? pat[63 - idx] : 1'b0;

  always @(posedge clk) cycles++;

  always @(posedge mdc) begin
    if (idx > 0) per = $time - last_rise;
    last_rise = $time;
    if (idx < 64) begin
      cap_o[63 - idx]  = mdio_o;
      cap_oe[63 - idx] = mdio_oe;
    end
    idx++;
  end
  always @(negedge mdc) hi = $time - last_rise;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic int ratio_exp(input logic [2:0] c);
    case (c)
      3'd0: return 42; 3'd1: return 62; 3'd2: return 16;
      3'd3: return 26; 3'd4: return 102; default: return 124;
    endcase
  endfunction

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(CTRL, r); chk(r == 0, "R1 ctrl reset", r, 0);
    rd(DATA, r); chk(r == 0, "R1 data reset", r, 0);
    chk(!mdc && !mdio_oe, "R1 mdc/oe reset", {mdc, mdio_oe}, 0);
    // R2 field storage while idle, no start
    wr(CTRL, 32'hFFFF_FFFE);
    rd(CTRL, r); chk(r == 32'h0000_FFDE, "R2 ctrl fields", r, 32'h0000_FFDE);
    wr(DATA, 32'hABCD_1234);
    rd(DATA, r); chk(r == 32'h0000_1234, "R2 data upper zero", r, 32'h0000_1234);
    rd(8'h18, r); chk(r == 0, "R2 unmapped", r, 0);
    repeat (300) @(negedge clk);
    chk(idx == 0 && !mdc, "R3 no start without bit0", idx, 0);

    for (int i = 0; i < 8; i++) begin
      logic [2:0] c; logic d; logic [4:0] p, g; logic [15:0] v;
      logic [63:0] fexp, oexp; logic [31:0] cexp; int rt, wait_n;
      {c, d, p, g, v} = VECS[i];
      rt = ratio_exp(c);
      fexp = {32'hFFFF_FFFF, 2'b01, d ? 2'b01 : 2'b10, p, g, d ? 2'b10 : 2'b00, v};
      oexp = d ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'b0};
      cexp = {16'b0, p, g, 1'b0, c, d, 1'b0};
      pat  = {{46{1'b1}}, 2'b00, v};
      wr(DATA, d ? {16'h0, v} : {16'h0, ~v});
      idx = 0;
      wr(CTRL, cexp | 32'h1);
      rd(CTRL, r); chk(r[0] == 1'b1, "R3 busy set", r, cexp | 1);
      wr(DATA, 32'h0000_DEAD);   // R7 ignored while busy
      wr(CTRL, 32'h0000_0000);   // R7 ignored while busy
      wait_n = 0;
      do begin rd(CTRL, r); wait_n++; end while (r[0] && wait_n < 20000);
      chk(idx == 64, "R3 64 mdc edges", idx, 64);
      chk(per == rt * CLK_NS, "R4 mdc period", per, rt * CLK_NS);
      chk(hi == (rt / 2) * CLK_NS, "R4 mdc high time", hi, (rt / 2) * CLK_NS);
      chk(cap_oe == oexp, d ? "R5 oe write" : "R6 oe release", cap_oe, oexp);
      if (d) chk(cap_o == fexp, "R5 write frame", cap_o, fexp);
      else   chk(cap_o[63:18] == fexp[63:18], "R6 read header", cap_o[63:18], fexp[63:18]);
      rd(DATA, r);
      chk(r == {16'h0, v}, d ? "R7 data kept" : "R6 read data", r, {16'h0, v});
      rd(CTRL, r); chk(r == cexp, "R7 ctrl kept, busy clear", r, cexp);
      chk(!mdc && !mdio_oe, "R8 idle mdc low", {mdc, mdio_oe}, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule